// File: doc/BRIEF.md
# Variable line-size cache controller

This block is a direct-mapped data cache in which the amount of data fetched on a miss can be changed at run time. The storage is cut into fixed 32-byte sub-lines, and each sub-line has its own tag and valid flag. A 2-bit line-size register selects how many of those sub-lines a miss brings in: 1, 2, 4 or 8. The register is written by software, typically at the entry of a routine whose preferred granularity is known in advance. No hardware monitor chooses the size.

On a read miss, the controller fetches the aligned group of sub-lines that contains the missed word. The group comes from a wide backing memory, one 32-byte beat per sub-line, in ascending address order. Every sub-line in the group gets the missed tag. Writes are write-through and do not allocate. A write hit updates the cached word, and every write is forwarded to memory.

Three counters feed an energy model: accepted accesses, lookups that missed, and activated 32-byte memory sub-arrays. The last one is one per memory command.

Top module: `vls_cache`

## Requirements
- R1: After reset, `busy`, `resp_valid` and all three counters are 0, and every sub-line is invalid, so the first access to any address misses.
- R2: The line-size code `ls_wdata` maps 0, 1, 2 and 3 to 32, 64, 128 and 256 bytes. A read miss issues exactly 1, 2, 4 or 8 memory read commands.
- R3: A fill starts at the sub-line address of the miss with its low `ls` bits cleared and steps up by one per command. While `mem_cmd_valid` is high and `mem_cmd_ready` is low, the address and direction hold.
- R4: A lookup hits exactly when the addressed sub-line is valid and its stored tag equals the request tag, whatever the current line size. The request tag is word address bits [13:7], and the index is bits [6:3].
- R5: A line-size write has no effect on an access accepted in the same cycle and applies to later accesses. It does not invalidate any sub-line.
- R6: A read returns on `resp_rdata` the 32-bit word at word address bits [2:0] of its sub-line, with `resp_hit` telling hit from miss. A miss returns the word fetched from memory.
- R7: A write issues one memory write command carrying the sub-line address, word select and data. On a hit, the cached word is also updated. On a miss, nothing is allocated.
- R8: `busy` is high from the cycle after a request is accepted until the response. `resp_valid` is a one-cycle pulse in the cycle `busy` falls. Requests presented while `busy` is high are ignored.
- R9: `cnt_access` counts accepted requests. `cnt_miss` counts lookups that missed, reads and writes alike. `cnt_subarr` counts accepted memory commands.
- R10: A fill writes only the sub-lines of its group. A sub-line outside the group keeps its tag and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ls_we | input | 1 | Line-size register write strobe |
| ls_wdata | input | 2 | Line-size code (0:32B, 1:64B, 2:128B, 3:256B) |
| req_valid | input | 1 | Processor request, accepted when `busy` is low |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 14 | Word address: tag [13:7], index [6:3], word select [2:0] |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Stall: a request is in progress |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Lookup hit flag for the response |
| resp_rdata | output | 32 | Read data (0 for writes) |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory command accepted |
| mem_cmd_write | output | 1 | 1 for write-through, 0 for sub-line read |
| mem_cmd_addr | output | 11 | Sub-line address |
| mem_cmd_wsel | output | 3 | Word select of a write |
| mem_cmd_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 256 | One 32-byte sub-line |
| cnt_access | output | 16 | Accepted access count |
| cnt_miss | output | 16 | Miss count |
| cnt_subarr | output | 16 | Activated memory sub-array count |

## Verification
The bench sweeps all four line sizes. For each size it misses into the middle of an aligned region and then probes all eight neighbouring sub-lines. A design with a wrong group mask or base address fetches the wrong beats, or reports hits for sub-lines it never filled. Shrinking the line size after a 256-byte fill must leave the far sub-lines hitting: a design that flushed on a size change, or that compared a whole-group tag, would miss there. A small fill into one slot of a large group must evict only that slot. A write miss followed by a read must miss, which catches an allocating write. A stall on the memory handshake and requests held high during `busy` expose designs that move the command address while stalled or that take a second request early.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int WORD_BITS = 32;
  localparam int WPS       = 8;
  localparam int SUB_BITS  = WORD_BITS * WPS;
  localparam int WSEL_W    = $clog2(WPS);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_FREQ, S_FWAIT, S_WR} vls_state_t;

  // highest sub-line offset inside a group for a line-size code
  function automatic logic [2:0] grp_last(input logic [1:0] code);
    case (code)
      2'd0:    grp_last = 3'd0;
      2'd1:    grp_last = 3'd1;
      2'd2:    grp_last = 3'd3;
      default: grp_last = 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/vls_tag_store.sv
module vls_tag_store #(
  parameter int NSUB  = 16,
  parameter int TAG_W = 7,
  localparam int IDX_W = $clog2(NSUB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [NSUB-1:0]  vld;
  logic [TAG_W-1:0] tags [NSUB];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_idx] <= wr_tag;
  end

  assign rd_valid = vld[rd_idx];
  assign rd_tag   = tags[rd_idx];
endmodule

// File: rtl/vls_data_ram.sv
module vls_data_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_q,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/vls_stats.sv
module vls_stats #(
  parameter int N = 3,
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        inc,
  output logic [N-1:0][W-1:0] cnt
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [W-1:0] c;
    always_ff @(posedge clk) begin
      if (rst) c <= '0;
      else if (inc[g]) c <= c + 1'b1;
    end
    assign cnt[g] = c;
  end
endmodule

// File: rtl/vls_cache.sv
module vls_cache
  import vls_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int NSUB   = 16,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(NSUB),
  localparam int SLA_W = ADDR_W - WSEL_W,
  localparam int TAG_W = SLA_W - IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ls_we,
  input  logic [1:0]           ls_wdata,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [WORD_BITS-1:0] req_wdata,
  output logic                 busy,
  output logic                 resp_valid,
  output logic                 resp_hit,
  output logic [WORD_BITS-1:0] resp_rdata,
  output logic                 mem_cmd_valid,
  input  logic                 mem_cmd_ready,
  output logic                 mem_cmd_write,
  output logic [SLA_W-1:0]     mem_cmd_addr,
  output logic [WSEL_W-1:0]    mem_cmd_wsel,
  output logic [WORD_BITS-1:0] mem_cmd_wdata,
  input  logic                 mem_rvalid,
  input  logic [SUB_BITS-1:0]  mem_rdata,
  output logic [CNT_W-1:0]     cnt_access,
  output logic [CNT_W-1:0]     cnt_miss,
  output logic [CNT_W-1:0]     cnt_subarr
);
  vls_state_t st;
  logic [1:0]           ls_reg, ls_cur;
  logic [SLA_W-1:0]     r_sla;
  logic [WSEL_W-1:0]    r_wsel;
  logic                 r_we, hit_q;
  logic [WORD_BITS-1:0] r_wdata, cap;
  logic [2:0]           k;

  logic                 accept, lhit, t_valid, fill_we, ram_we;
  logic [TAG_W-1:0]     t_tag, r_tag;
  logic [IDX_W-1:0]     r_idx, fill_idx, ram_wa;
  logic [2:0]           glast, tgt_k;
  logic [SLA_W-1:0]     base_sla, fill_sla;
  logic [SUB_BITS-1:0]  ram_q, merged, ram_wd;
  logic [WORD_BITS-1:0] beat_word, q_word;
  logic [2:0][CNT_W-1:0] cnts;

  assign accept   = (st == S_IDLE) && req_valid;
  assign r_idx    = r_sla[IDX_W-1:0];
  assign r_tag    = r_sla[SLA_W-1:IDX_W];
  assign glast    = grp_last(ls_cur);
  assign tgt_k    = r_sla[2:0] & glast;
  assign base_sla = r_sla & ~SLA_W'(glast);
  assign fill_sla = base_sla + SLA_W'(k);
  assign fill_idx = fill_sla[IDX_W-1:0];
  assign lhit     = t_valid && (t_tag == r_tag);
  assign fill_we  = (st == S_FWAIT) && mem_rvalid;
  assign beat_word = mem_rdata[r_wsel*WORD_BITS +: WORD_BITS];
  assign q_word    = ram_q[r_wsel*WORD_BITS +: WORD_BITS];

  always_comb begin
    merged = ram_q;
    merged[r_wsel*WORD_BITS +: WORD_BITS] = r_wdata;
  end

  assign ram_we = fill_we || ((st == S_LOOK) && r_we && lhit);
  assign ram_wa = fill_we ? fill_idx : r_idx;
  assign ram_wd = fill_we ? mem_rdata : merged;

  vls_tag_store #(.NSUB(NSUB), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .rd_idx(r_idx), .rd_valid(t_valid), .rd_tag(t_tag),
    .wr_en(fill_we), .wr_idx(fill_idx), .wr_tag(r_tag)
  );

  vls_data_ram #(.DEPTH(NSUB), .WIDTH(SUB_BITS)) u_ram (
    .clk(clk), .rd_en(accept), .rd_addr(req_addr[WSEL_W +: IDX_W]), .rd_q(ram_q),
    .wr_en(ram_we), .wr_addr(ram_wa), .wr_data(ram_wd)
  );

  vls_stats #(.N(3), .W(CNT_W)) u_stats (
    .clk(clk), .rst(rst),
    .inc({mem_cmd_valid && mem_cmd_ready, (st == S_LOOK) && !lhit, accept}),
    .cnt(cnts)
  );
  assign cnt_access = cnts[0];
  assign cnt_miss   = cnts[1];
  assign cnt_subarr = cnts[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ls_reg <= 2'd0; ls_cur <= 2'd0;
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_rdata <= '0;
      r_sla <= '0; r_wsel <= '0; r_we <= 1'b0; r_wdata <= '0;
      hit_q <= 1'b0; cap <= '0; k <= 3'd0;
    end else begin
      resp_valid <= 1'b0;
      if (ls_we) ls_reg <= ls_wdata;
      case (st)
        S_IDLE: if (accept) begin
          r_sla   <= req_addr[ADDR_W-1:WSEL_W];
          r_wsel  <= req_addr[WSEL_W-1:0];
          r_we    <= req_we;
          r_wdata <= req_wdata;
          ls_cur  <= ls_reg;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          hit_q <= lhit;
          k     <= 3'd0;
          if (r_we) st <= S_WR;
          else if (lhit) begin
            resp_valid <= 1'b1; resp_hit <= 1'b1; resp_rdata <= q_word;
            st <= S_IDLE;
          end else st <= S_FREQ;
        end
        S_FREQ: if (mem_cmd_ready) st <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) begin
          if (k == tgt_k) cap <= beat_word;
          if (k == glast) begin
            resp_valid <= 1'b1; resp_hit <= 1'b0;
            resp_rdata <= (k == tgt_k) ? beat_word : cap;
            st <= S_IDLE;
          end else begin
            k  <= k + 3'd1;
            st <= S_FREQ;
          end
        end
        S_WR: if (mem_cmd_ready) begin
          resp_valid <= 1'b1; resp_hit <= hit_q; resp_rdata <= '0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy          = (st != S_IDLE);
  assign mem_cmd_valid = (st == S_FREQ) || (st == S_WR);
  assign mem_cmd_write = (st == S_WR);
  assign mem_cmd_addr  = (st == S_WR) ? r_sla : fill_sla;
  assign mem_cmd_wsel  = r_wsel;
  assign mem_cmd_wdata = r_wdata;
endmodule

// File: rtl/vls_cache_chk.sv
module vls_cache_chk #(
  parameter int SLA_W = 11,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             busy,
  input logic             resp_valid,
  input logic             mem_cmd_valid,
  input logic             mem_cmd_ready,
  input logic             mem_cmd_write,
  input logic [SLA_W-1:0] mem_cmd_addr,
  input logic [CNT_W-1:0] cnt_access,
  input logic [CNT_W-1:0] cnt_miss
);
  // R3: a stalled memory command holds
  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_write)));

  // R8: response comes as busy falls
  p_resp_end_r8: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (!busy && $past(busy)));

  // R8: response is a single-cycle pulse
  p_resp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R8: no memory traffic while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_cmd_valid);

  // R9: an accepted request advances the access count by one
  p_acc_step_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (cnt_access == $past(cnt_access) + 1'b1));

  // R9: misses never exceed accesses
  p_miss_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_miss <= cnt_access);
endmodule

bind vls_cache vls_cache_chk #(.SLA_W(SLA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
  .resp_valid(resp_valid), .mem_cmd_valid(mem_cmd_valid),
  .mem_cmd_ready(mem_cmd_ready), .mem_cmd_write(mem_cmd_write),
  .mem_cmd_addr(mem_cmd_addr), .cnt_access(cnt_access), .cnt_miss(cnt_miss)
);

// File: tb/sim_vls_cache.sv
module sim_vls_cache;
  localparam int AW = 14, SLW = 11, CW = 16, NSL = 2048;

  logic clk = 1'b0, rst = 1'b1;
  logic ls_we = 1'b0; logic [1:0] ls_wdata = 2'd0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0; logic [31:0] req_wdata = '0;
  logic busy, resp_valid, resp_hit; logic [31:0] resp_rdata;
  logic mem_cmd_valid, mem_cmd_ready, mem_cmd_write;
  logic [SLW-1:0] mem_cmd_addr; logic [2:0] mem_cmd_wsel; logic [31:0] mem_cmd_wdata;
  logic mem_rvalid; logic [255:0] mem_rdata;
  logic [CW-1:0] cnt_access, cnt_miss, cnt_subarr;

  always #5 clk = ~clk;

  vls_cache u0 (
    .clk(clk), .rst(rst), .ls_we(ls_we), .ls_wdata(ls_wdata),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_write(mem_cmd_write),
    .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wsel(mem_cmd_wsel), .mem_cmd_wdata(mem_cmd_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cnt_access(cnt_access), .cnt_miss(cnt_miss), .cnt_subarr(cnt_subarr)
  );

  int total = 0, bad = 0;
  logic [255:0] mem [NSL];
  int n_cmd = 0, stall_len = 0;
  logic [SLW-1:0] log_a [16];
  logic log_w [16];
  bit rv [16]; int rt [16];
  int ls_m = 0, e_acc = 0, e_miss = 0, e_sub = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    int phase, hold; logic [SLW-1:0] ca; logic cw;
    phase = 0; hold = 0; ca = '0; cw = 1'b0;
    mem_cmd_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    for (int s = 0; s < NSL; s++)
      for (int w = 0; w < 8; w++)
        mem[s][w*32 +: 32] = (32'(s) * 32'h0001_0003) ^ (32'(w) * 32'h1100_0000) ^ 32'h0000_5A5A;
    forever begin
      @(negedge clk);
      if (phase == 1) begin
        mem_cmd_ready = 1'b0;
        if (!cw) begin mem_rvalid = 1'b1; mem_rdata = mem[ca]; phase = 2; end
        else phase = 0;
      end else if (phase == 2) begin
        mem_rvalid = 1'b0; phase = 0;
      end else if (mem_cmd_valid && !rst) begin
        if (hold < stall_len) hold++;
        else begin
          hold = 0; ca = mem_cmd_addr; cw = mem_cmd_write;
          if (n_cmd < 16) begin log_a[n_cmd] = ca; log_w[n_cmd] = cw; end
          n_cmd++;
          if (cw) mem[ca][mem_cmd_wsel*32 +: 32] = mem_cmd_wdata;
          mem_cmd_ready = 1'b1; phase = 1;
        end
      end
    end
  end

  task automatic set_ls(input int code);
    @(negedge clk);
    ls_we = 1'b1; ls_wdata = 2'(code);
    @(negedge clk);
    ls_we = 1'b0;
    ls_m = code;
  endtask

  task automatic do_acc(input bit we, input int sla, input int wsel, input logic [31:0] wd,
                        input int extra, input string tag);
    int idx, tg, g, base, ncmd; bit eh; logic [31:0] erd;
    int ea [8]; bit ew [8];
    idx = sla % 16; tg = sla / 16;
    eh = rv[idx] && (rt[idx] == tg);
    erd = mem[sla][wsel*32 +: 32];
    e_acc++;
    if (!eh) e_miss++;
    if (we) begin
      ncmd = 1; ea[0] = sla; ew[0] = 1'b1;
      erd = 32'h0;
    end else if (!eh) begin
      g = 1 << ls_m; base = sla & ~(g - 1); ncmd = g;
      for (int j = 0; j < g; j++) begin
        ea[j] = base + j; ew[j] = 1'b0;
        rv[(base + j) % 16] = 1'b1; rt[(base + j) % 16] = tg;
      end
    end else ncmd = 0;
    e_sub += ncmd;
    n_cmd = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = AW'(sla * 8 + wsel); req_wdata = wd;
    @(negedge clk);
    if (extra > 0) begin
      req_addr = req_addr ^ 14'h2AAA; req_we = ~we;
      repeat (extra) @(negedge clk);
    end
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    chk(resp_hit == eh, tag, "hit", longint'(resp_hit), longint'(eh));
    if (!we) chk(resp_rdata == erd, (eh ? "R6" : tag), "rdata", longint'(resp_rdata), longint'(erd));
    chk(n_cmd == ncmd, tag, "cmd count", n_cmd, ncmd);
    for (int j = 0; j < ncmd && j < n_cmd; j++) begin
      chk(int'(log_a[j]) == ea[j], "R3", "cmd addr", longint'(log_a[j]), ea[j]);
      chk(log_w[j] == ew[j], (we ? "R7" : "R2"), "cmd dir", longint'(log_w[j]), longint'(ew[j]));
    end
    chk(int'(cnt_access) == e_acc, "R9", "cnt_access", longint'(cnt_access), e_acc);
    chk(int'(cnt_miss) == e_miss, "R9", "cnt_miss", longint'(cnt_miss), e_miss);
    chk(int'(cnt_subarr) == e_sub, "R9", "cnt_subarr", longint'(cnt_subarr), e_sub);
  endtask

  initial begin
    int seed;
    for (int i = 0; i < 16; i++) begin rv[i] = 1'b0; rt[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy", longint'(busy), 0);
    chk(resp_valid == 1'b0, "R1", "resp_valid", longint'(resp_valid), 0);
    chk(cnt_access == 0 && cnt_miss == 0 && cnt_subarr == 0, "R1", "counters",
        longint'(cnt_access) + longint'(cnt_miss) + longint'(cnt_subarr), 0);
    do_acc(1'b0, 0, 0, 32'h0, 0, "R1");

    // R2, R3, R4: sweep every line size, probe the 8-sub-line neighbourhood
    for (int ls = 0; ls < 4; ls++) begin
      set_ls(ls);
      stall_len = ls % 3;
      do_acc(1'b0, (8 + ls) * 16 + 5, ls, 32'h0, 0, "R2");
      for (int i = 0; i < 8; i++) do_acc(1'b0, (8 + ls) * 16 + i, i, 32'h0, 0, "R4");
    end

    // R5: shrinking the size keeps earlier fills
    set_ls(3);
    do_acc(1'b0, 20 * 16 + 2, 1, 32'h0, 0, "R5");
    set_ls(0);
    do_acc(1'b0, 20 * 16 + 6, 4, 32'h0, 0, "R5");
    // R5: a size write in the accept cycle does not apply to that access
    @(negedge clk);
    ls_we = 1'b1; ls_wdata = 2'd3;
    req_valid = 1'b1; req_we = 1'b0; req_addr = AW'((22 * 16 + 9) * 8);
    @(negedge clk);
    ls_we = 1'b0; req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    chk(n_cmd == 1, "R5", "same-cycle size write beats", n_cmd, 1);
    e_acc++; e_miss++; e_sub++;
    rv[9] = 1'b1; rt[9] = 22;
    ls_m = 3;
    set_ls(0);

    // R10: a one-sub-line fill evicts only its own slot
    do_acc(1'b0, 21 * 16 + 3, 0, 32'h0, 0, "R10");
    do_acc(1'b0, 20 * 16 + 4, 7, 32'h0, 0, "R10");
    do_acc(1'b0, 20 * 16 + 3, 2, 32'h0, 0, "R10");

    // R7: write hit updates and forwards; write miss does not allocate
    set_ls(1);
    do_acc(1'b1, 20 * 16 + 4, 2, 32'hDEAD_BEEF, 0, "R7");
    do_acc(1'b0, 20 * 16 + 4, 2, 32'h0, 0, "R7");
    do_acc(1'b1, 30 * 16 + 9, 5, 32'h1234_5678, 0, "R7");
    do_acc(1'b0, 30 * 16 + 9, 5, 32'h0, 0, "R7");

    // R8: requests held during busy are ignored
    stall_len = 2;
    do_acc(1'b0, 40 * 16 + 1, 3, 32'h0, 2, "R8");
    do_acc(1'b1, 40 * 16 + 1, 6, 32'hCAFE_0001, 2, "R8");
    stall_len = 0;

    // near-exhaustive mixed traffic over a small tag range
    seed = 32'h1357;
    for (int n = 0; n < 300; n++) begin
      seed = seed * 1103515245 + 12345;
      if (((seed >>> 8) & 7) == 0) set_ls((seed >>> 4) & 3);
      stall_len = n % 3;
      do_acc(((seed >>> 24) & 7) == 0, ((seed >>> 16) & 3) * 16 + ((seed >>> 20) & 15),
             (seed >>> 12) & 7, 32'(seed), 0, "R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule